// File: doc/BRIEF.md
# General-Purpose Timer Register Front End

This block is the register-access and interrupt side of a general-purpose timer. It decodes 32-bit reads and writes, and reads and writes split into two 16-bit halves. It holds the timer's configuration, control, reload and match values and its interrupt enable, wake-up enable and status bits. It turns three event pulses from the counting datapath into a level interrupt and a one-cycle wake-up pulse. Those events are a match, an overflow and a capture.

The counter and the capture logic sit outside this block. They supply the live count and the two captured values as inputs. In return they receive the stored control, reload and match values and single-cycle strobes. The strobes signal a counter load, a trigger (reload from the reload value), a capture re-arm and a soft reset.

Register offsets (byte addresses, word-aligned): 0x00 identity, 0x10 configuration, 0x14 system status, 0x18 interrupt status, 0x1C interrupt enable, 0x20 wake-up enable, 0x24 control, 0x28 counter, 0x2C reload, 0x30 trigger, 0x34 write-pending, 0x38 match, 0x3C first capture, 0x40 interface control, 0x44 second capture.

Top module: `tmrif_top`

## Requirements
- R1: Reads return fixed constants: 0x00 gives the identity value 0x21, 0x14 gives 1, 0x34 gives 0 and 0x30 gives 0xFFFFFFFF. Reading an unmapped offset gives 0.
- R2: After reset, interface control (0x40) reads 4, meaning bit 2 is the posted flag set to 1. Every other stored register reads 0, and `irq` and `wkup` are low.
- R3: Event bit positions are: bit 0 match, bit 1 overflow, bit 2 capture. The interrupt enable (0x1C) and wake-up enable (0x20) registers keep only bits 2:0.
- R4: An event sets its status bit (0x18) at the clock edge where it is sampled, but only if that bit's interrupt enable is set. If an event and a clear of the same bit arrive together, the bit ends set.
- R5: `irq` is high exactly while at least one status bit is set.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: An event whose wake-up enable bit is set raises `wkup` for exactly the one cycle after the edge that samples the event. This happens whatever the interrupt enable is.
- R8: A configuration write (0x10) stores only the bits in mask 0x33D.
- R9: A write with bit 1 set to configuration (0x10) or interface control (0x40) pulses `soft_rst` and returns every register to its reset value.
- R10: A 16-bit write to a low half (address bit 1 = 0) is only buffered. A 16-bit write to the high half commits {new data, buffered half} as one 32-bit write to that word.
- R11: A 16-bit read of a low half returns the low 16 bits and latches the high 16 bits. A 16-bit read of a high half returns the latched value.
- R12: Writes to read-only offsets (0x00, 0x14, 0x34, 0x3C, 0x44) and to unmapped offsets change nothing.
- R13: Reads of 0x28, 0x3C and 0x44 return `cnt_in`, `cap1_in` and `cap2_in`. A committed write raises a strobe in the same cycle: to 0x28 raises `cnt_load` with the data on `cnt_wdata`; to 0x30 raises `trig_load`; to 0x18 with bit 2 set raises `capt_rearm`.
- R14: Control (0x24) keeps bits 14:0. Reload (0x2C) and match (0x38) keep all 32 bits. These values appear on `ctrl_q`, `reload_q` and `match_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = 16-bit access on data bits 15:0 |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle (0 when not reading) |
| ev_in | input | 3 | Event pulses: bit0 match, bit1 overflow, bit2 capture |
| cnt_in | input | 32 | Live counter value |
| cap1_in | input | 32 | First captured value |
| cap2_in | input | 32 | Second captured value |
| irq | output | 1 | Level interrupt |
| wkup | output | 1 | One-cycle wake-up pulse |
| soft_rst | output | 1 | Soft-reset strobe |
| cnt_load | output | 1 | Counter load strobe |
| cnt_wdata | output | 32 | Value to load into the counter |
| trig_load | output | 1 | Trigger strobe |
| capt_rearm | output | 1 | Capture re-arm strobe |
| cfg_q | output | 32 | Stored configuration |
| ctrl_q | output | 32 | Stored control |
| reload_q | output | 32 | Stored reload value |
| match_q | output | 32 | Stored match value |
| posted_q | output | 1 | Posted-mode flag |

## Verification
Several properties are checked on every cycle:
- A rise of `irq` always traces back to an enabled event.
- A fall of `irq` always follows a bus write.
- `wkup` pulses exactly after a wake-enabled event.
- The soft-reset and counter-load strobes appear only during a write commit.
- The posted flag is set after reset.

Other behaviour can only be shown by the bench's scenarios:
- The address map and its constants.
- The bit masks.
- Half-word assembly and the read latch.
- Set-beats-clear on the status bits.
- The way a soft reset restores each register.

// File: rtl/tmrif_pkg.sv
package tmrif_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int IX_W   = ADDR_W - 2;
    localparam int NEV    = 3;

    // event bit positions
    localparam int EV_MAT = 0;
    localparam int EV_OVF = 1;
    localparam int EV_CAP = 2;

    localparam logic [DATA_W-1:0] CFG_MASK = 32'h0000_033D;
    localparam logic [DATA_W-1:0] CTL_MASK = 32'h0000_7FFF;
    localparam int SRST_BIT   = 1;
    localparam int POSTED_BIT = 2;

    // word indices (byte offset / 4)
    localparam logic [IX_W-1:0] IX_ID   = 6'd0;
    localparam logic [IX_W-1:0] IX_CFG  = 6'd4;
    localparam logic [IX_W-1:0] IX_SYS  = 6'd5;
    localparam logic [IX_W-1:0] IX_ISR  = 6'd6;
    localparam logic [IX_W-1:0] IX_IER  = 6'd7;
    localparam logic [IX_W-1:0] IX_WER  = 6'd8;
    localparam logic [IX_W-1:0] IX_CTL  = 6'd9;
    localparam logic [IX_W-1:0] IX_CNT  = 6'd10;
    localparam logic [IX_W-1:0] IX_RLD  = 6'd11;
    localparam logic [IX_W-1:0] IX_TRG  = 6'd12;
    localparam logic [IX_W-1:0] IX_WPS  = 6'd13;
    localparam logic [IX_W-1:0] IX_MAT  = 6'd14;
    localparam logic [IX_W-1:0] IX_CAP1 = 6'd15;
    localparam logic [IX_W-1:0] IX_IFC  = 6'd16;
    localparam logic [IX_W-1:0] IX_CAP2 = 6'd17;

    typedef struct packed {
        logic cfg;
        logic isr;
        logic ier;
        logic wer;
        logic ctl;
        logic cnt;
        logic rld;
        logic trg;
        logic mat;
        logic ifc;
    } wsel_t;

    function automatic wsel_t decode_wr(input logic [IX_W-1:0] ix, input logic we);
        wsel_t s;
        s.cfg = we && (ix == IX_CFG);
        s.isr = we && (ix == IX_ISR);
        s.ier = we && (ix == IX_IER);
        s.wer = we && (ix == IX_WER);
        s.ctl = we && (ix == IX_CTL);
        s.cnt = we && (ix == IX_CNT);
        s.rld = we && (ix == IX_RLD);
        s.trg = we && (ix == IX_TRG);
        s.mat = we && (ix == IX_MAT);
        s.ifc = we && (ix == IX_IFC);
        return s;
    endfunction
endpackage

// File: rtl/tmrif_half.sv
module tmrif_half
    import tmrif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_half,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] word_rd,
    output logic              acc_we,
    output logic [IX_W-1:0]   acc_ix,
    output logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [HALF_W-1:0] wbuf_q;
    logic [HALF_W-1:0] rlat_q;
    logic hi_sel;
    logic lo_half_wr;
    logic lo_half_rd;
    logic unused_addr0;

    assign unused_addr0 = bus_addr[0];
    assign hi_sel     = bus_addr[1];
    assign acc_ix     = bus_addr[ADDR_W-1:2];
    assign lo_half_wr = bus_sel && bus_wr && bus_half && !hi_sel;
    assign lo_half_rd = bus_sel && !bus_wr && bus_half && !hi_sel;

    // a low-half write only fills the buffer; everything else commits
    assign acc_we    = bus_sel && bus_wr && !(bus_half && !hi_sel);
    assign acc_wdata = bus_half ? {bus_wdata[HALF_W-1:0], wbuf_q} : bus_wdata;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (!bus_half)
                bus_rdata = word_rd;
            else if (!hi_sel)
                bus_rdata = {{HALF_W{1'b0}}, word_rd[HALF_W-1:0]};
            else
                bus_rdata = {{HALF_W{1'b0}}, rlat_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            wbuf_q <= '0;
            rlat_q <= '0;
        end else begin
            if (lo_half_wr) wbuf_q <= bus_wdata[HALF_W-1:0];
            if (lo_half_rd) rlat_q <= word_rd[DATA_W-1:HALF_W];
        end
    end
endmodule

// File: rtl/tmrif_irq.sv
module tmrif_irq
    import tmrif_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           srst,
    input  logic           isr_we,
    input  logic           ier_we,
    input  logic           wer_we,
    input  logic [NEV-1:0] wbits,
    input  logic [NEV-1:0] ev,
    output logic [NEV-1:0] status_q,
    output logic [NEV-1:0] ien_q,
    output logic [NEV-1:0] wen_q,
    output logic           irq,
    output logic           wkup
);
    logic [NEV-1:0] st_nx;

    for (genvar i = 0; i < NEV; i++) begin : g_ev
        // an enabled event wins over a simultaneous write-one-to-clear
        assign st_nx[i] = (ev[i] && ien_q[i]) ? 1'b1 :
                          (isr_we && wbits[i]) ? 1'b0 : status_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            status_q <= '0;
            ien_q    <= '0;
            wen_q    <= '0;
        end else begin
            status_q <= st_nx;
            if (ier_we) ien_q <= wbits;
            if (wer_we) wen_q <= wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wkup <= 1'b0;
        else     wkup <= |(ev & wen_q);
    end

    assign irq = |status_q;
endmodule

// File: rtl/tmrif_regs.sv
module tmrif_regs
    import tmrif_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VAL = 32'h21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_we,
    input  logic [IX_W-1:0]   acc_ix,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [NEV-1:0]    status_q,
    input  logic [NEV-1:0]    ien_q,
    input  logic [NEV-1:0]    wen_q,
    input  logic [DATA_W-1:0] cnt_in,
    input  logic [DATA_W-1:0] cap1_in,
    input  logic [DATA_W-1:0] cap2_in,
    output wsel_t             wsel,
    output logic              srst,
    output logic [DATA_W-1:0] word_rd,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] ctl_q,
    output logic [DATA_W-1:0] rld_q,
    output logic [DATA_W-1:0] mat_q,
    output logic              posted_q
);
    localparam int PADW = DATA_W - NEV;

    assign wsel = decode_wr(acc_ix, acc_we);
    assign srst = (wsel.cfg || wsel.ifc) && acc_wdata[SRST_BIT];

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            cfg_q    <= '0;
            ctl_q    <= '0;
            rld_q    <= '0;
            mat_q    <= '0;
            posted_q <= 1'b1;
        end else begin
            if (wsel.cfg) cfg_q    <= acc_wdata & CFG_MASK;
            if (wsel.ctl) ctl_q    <= acc_wdata & CTL_MASK;
            if (wsel.rld) rld_q    <= acc_wdata;
            if (wsel.mat) mat_q    <= acc_wdata;
            if (wsel.ifc) posted_q <= acc_wdata[POSTED_BIT];
        end
    end

    always_comb begin
        unique case (acc_ix)
            IX_ID:   word_rd = ID_VAL;
            IX_CFG:  word_rd = cfg_q;
            IX_SYS:  word_rd = 32'd1;
            IX_ISR:  word_rd = {{PADW{1'b0}}, status_q};
            IX_IER:  word_rd = {{PADW{1'b0}}, ien_q};
            IX_WER:  word_rd = {{PADW{1'b0}}, wen_q};
            IX_CTL:  word_rd = ctl_q;
            IX_CNT:  word_rd = cnt_in;
            IX_RLD:  word_rd = rld_q;
            IX_TRG:  word_rd = '1;
            IX_WPS:  word_rd = '0;
            IX_MAT:  word_rd = mat_q;
            IX_CAP1: word_rd = cap1_in;
            IX_IFC:  word_rd = {{(DATA_W-3){1'b0}}, posted_q, 2'b00};
            IX_CAP2: word_rd = cap2_in;
            default: word_rd = '0;
        endcase
    end
endmodule

// File: rtl/tmrif_top.sv
module tmrif_top
    import tmrif_pkg::*;
#(
    parameter logic [31:0] ID_VAL = 32'h21
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_half,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [2:0]  ev_in,
    input  logic [31:0] cnt_in,
    input  logic [31:0] cap1_in,
    input  logic [31:0] cap2_in,
    output logic        irq,
    output logic        wkup,
    output logic        soft_rst,
    output logic        cnt_load,
    output logic [31:0] cnt_wdata,
    output logic        trig_load,
    output logic        capt_rearm,
    output logic [31:0] cfg_q,
    output logic [31:0] ctrl_q,
    output logic [31:0] reload_q,
    output logic [31:0] match_q,
    output logic        posted_q
);
    logic              acc_we;
    logic [IX_W-1:0]   acc_ix;
    logic [DATA_W-1:0] acc_wdata;
    logic [DATA_W-1:0] word_rd;
    wsel_t             wsel;
    logic              srst;
    logic [NEV-1:0]    status_q, ien_q, wen_q;

    tmrif_half u_half (
        .clk(clk), .rst(rst), .srst(srst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_half(bus_half),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .word_rd(word_rd),
        .acc_we(acc_we), .acc_ix(acc_ix), .acc_wdata(acc_wdata),
        .bus_rdata(bus_rdata)
    );

    tmrif_regs #(.ID_VAL(ID_VAL)) u_regs (
        .clk(clk), .rst(rst), .acc_we(acc_we), .acc_ix(acc_ix),
        .acc_wdata(acc_wdata), .status_q(status_q), .ien_q(ien_q),
        .wen_q(wen_q), .cnt_in(cnt_in), .cap1_in(cap1_in),
        .cap2_in(cap2_in), .wsel(wsel), .srst(srst), .word_rd(word_rd),
        .cfg_q(cfg_q), .ctl_q(ctrl_q), .rld_q(reload_q), .mat_q(match_q),
        .posted_q(posted_q)
    );

    tmrif_irq u_irq (
        .clk(clk), .rst(rst), .srst(srst),
        .isr_we(wsel.isr), .ier_we(wsel.ier), .wer_we(wsel.wer),
        .wbits(acc_wdata[NEV-1:0]), .ev(ev_in),
        .status_q(status_q), .ien_q(ien_q), .wen_q(wen_q),
        .irq(irq), .wkup(wkup)
    );

    assign soft_rst   = srst;
    assign cnt_load   = wsel.cnt;
    assign cnt_wdata  = acc_wdata;
    assign trig_load  = wsel.trg;
    assign capt_rearm = wsel.isr && acc_wdata[EV_CAP];
endmodule

// File: rtl/tmrif_chk.sv
module tmrif_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] ev_in,
    input logic [2:0] ien_q,
    input logic [2:0] wen_q,
    input logic       irq,
    input logic       wkup,
    input logic       soft_rst,
    input logic       cnt_load,
    input logic       posted_q
);
    AST_IRQ_RISE_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(ev_in & ien_q)));  // R4
    AST_IRQ_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_sel && bus_wr));  // R6
    AST_WAKE_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (rst)
        (|(ev_in & wen_q)) |=> wkup);  // R7
    AST_WAKE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        wkup |-> $past(|(ev_in & wen_q)));  // R7
    AST_SRST_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (bus_sel && bus_wr));  // R9
    AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        cnt_load |-> (bus_sel && bus_wr));  // R13
    AST_POSTED_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> posted_q);  // R2
endmodule

bind tmrif_top tmrif_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .ev_in(ev_in), .ien_q(ien_q), .wen_q(wen_q), .irq(irq), .wkup(wkup),
    .soft_rst(soft_rst), .cnt_load(cnt_load), .posted_q(posted_q)
);

// File: tb/sim_tmrif_top.sv
module sim_tmrif_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  ev_in = '0;
    logic [31:0] cnt_in  = 32'h1234_5678;
    logic [31:0] cap1_in = 32'hCAFE_0001;
    logic [31:0] cap2_in = 32'h0BAD_0002;
    logic irq, wkup, soft_rst, cnt_load, trig_load, capt_rearm, posted_q;
    logic [31:0] cnt_wdata, cfg_q, ctrl_q, reload_q, match_q;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [31:0] rd_s, cd_s;
    logic ld_s, tg_s, rm_s, sr_s;

    always #4 clk = ~clk;

    tmrif_top u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ev_in(ev_in), .cnt_in(cnt_in),
        .cap1_in(cap1_in), .cap2_in(cap2_in), .irq(irq), .wkup(wkup),
        .soft_rst(soft_rst), .cnt_load(cnt_load), .cnt_wdata(cnt_wdata),
        .trig_load(trig_load), .capt_rearm(capt_rearm), .cfg_q(cfg_q),
        .ctrl_q(ctrl_q), .reload_q(reload_q), .match_q(match_q),
        .posted_q(posted_q)
    );

    // {req[4], wr, half, addr[8], wdata[32], expected[32]}
    localparam int NV = 37;
    localparam logic [77:0] VEC [NV] = '{
        {4'd1,  1'b0, 1'b0, 8'h00, 32'h0, 32'h0000_0021},   // R1 identity
        {4'd1,  1'b0, 1'b0, 8'h14, 32'h0, 32'h0000_0001},   // R1 reset done
        {4'd1,  1'b0, 1'b0, 8'h34, 32'h0, 32'h0000_0000},   // R1 write pending
        {4'd1,  1'b0, 1'b0, 8'h30, 32'h0, 32'hFFFF_FFFF},   // R1 trigger
        {4'd1,  1'b0, 1'b0, 8'h4C, 32'h0, 32'h0000_0000},   // R1 unmapped
        {4'd1,  1'b0, 1'b0, 8'h04, 32'h0, 32'h0000_0000},   // R1 unmapped
        {4'd2,  1'b0, 1'b0, 8'h40, 32'h0, 32'h0000_0004},   // R2 posted
        {4'd2,  1'b0, 1'b0, 8'h24, 32'h0, 32'h0000_0000},   // R2
        {4'd2,  1'b0, 1'b0, 8'h18, 32'h0, 32'h0000_0000},   // R2
        {4'd2,  1'b0, 1'b0, 8'h38, 32'h0, 32'h0000_0000},   // R2
        {4'd8,  1'b1, 1'b0, 8'h10, 32'hFFFF_FFFD, 32'h0},   // R8
        {4'd8,  1'b0, 1'b0, 8'h10, 32'h0, 32'h0000_033D},   // R8
        {4'd3,  1'b1, 1'b0, 8'h1C, 32'hFFFF_FFFF, 32'h0},   // R3
        {4'd3,  1'b0, 1'b0, 8'h1C, 32'h0, 32'h0000_0007},   // R3
        {4'd3,  1'b1, 1'b0, 8'h20, 32'hFFFF_FFF8, 32'h0},   // R3
        {4'd3,  1'b0, 1'b0, 8'h20, 32'h0, 32'h0000_0000},   // R3
        {4'd12, 1'b1, 1'b0, 8'h00, 32'h0000_0055, 32'h0},   // R12
        {4'd12, 1'b0, 1'b0, 8'h00, 32'h0, 32'h0000_0021},   // R12
        {4'd12, 1'b1, 1'b0, 8'h4C, 32'h1234_5678, 32'h0},   // R12
        {4'd12, 1'b0, 1'b0, 8'h4C, 32'h0, 32'h0000_0000},   // R12
        {4'd12, 1'b1, 1'b0, 8'h14, 32'h0, 32'h0},           // R12
        {4'd12, 1'b0, 1'b0, 8'h14, 32'h0, 32'h0000_0001},   // R12
        {4'd13, 1'b1, 1'b0, 8'h3C, 32'h0, 32'h0},           // R13 read-only
        {4'd13, 1'b0, 1'b0, 8'h3C, 32'h0, 32'hCAFE_0001},   // R13
        {4'd13, 1'b0, 1'b0, 8'h28, 32'h0, 32'h1234_5678},   // R13
        {4'd13, 1'b0, 1'b0, 8'h44, 32'h0, 32'h0BAD_0002},   // R13
        {4'd14, 1'b1, 1'b0, 8'h2C, 32'hA5A5_1234, 32'h0},   // R14
        {4'd14, 1'b0, 1'b0, 8'h2C, 32'h0, 32'hA5A5_1234},   // R14
        {4'd10, 1'b1, 1'b1, 8'h2C, 32'h0000_1111, 32'h0},   // R10 low buffered
        {4'd10, 1'b0, 1'b0, 8'h2C, 32'h0, 32'hA5A5_1234},   // R10 unchanged
        {4'd10, 1'b1, 1'b1, 8'h2E, 32'h0000_2222, 32'h0},   // R10 high commits
        {4'd10, 1'b0, 1'b0, 8'h2C, 32'h0, 32'h2222_1111},   // R10
        {4'd11, 1'b0, 1'b1, 8'h2C, 32'h0, 32'h0000_1111},   // R11 low half
        {4'd11, 1'b0, 1'b1, 8'h2E, 32'h0, 32'h0000_2222},   // R11 latched high
        {4'd14, 1'b1, 1'b0, 8'h24, 32'hFFFF_FFFF, 32'h0},   // R14
        {4'd14, 1'b0, 1'b0, 8'h24, 32'h0, 32'h0000_7FFF},   // R14
        {4'd14, 1'b1, 1'b0, 8'h38, 32'h0000_BEEF, 32'h0}    // R14
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic h, input logic [7:0] a,
                       input logic [31:0] d, input logic [2:0] e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_half = h; bus_addr = a;
        bus_wdata = d; ev_in = e;
        #2;
        rd_s = bus_rdata; cd_s = cnt_wdata; ld_s = cnt_load;
        tg_s = trig_load; rm_s = capt_rearm; sr_s = soft_rst;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_half = 1'b0; ev_in = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R2 irq after reset", {31'b0, irq}, 32'd0);
        chk("R2 wkup after reset", {31'b0, wkup}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][73], VEC[i][72], VEC[i][71:64], VEC[i][63:32], 3'b000);
            if (!VEC[i][73])
                chk($sformatf("R%0d vector %0d", VEC[i][77:74], i), rd_s, VEC[i][31:0]);
        end
        chk("R14 ctrl_q port", ctrl_q, 32'h7FFF);
        chk("R14 match_q port", match_q, 32'hBEEF);
        chk("R14 reload_q port", reload_q, 32'h2222_1111);
        chk("R8 cfg_q port", cfg_q, 32'h33D);

        // interrupt enables are 7, wake enables 0
        acc(1'b0, 1'b0, 8'h4C, 32'h0, 3'b001);
        chk("R5 irq after enabled match", {31'b0, irq}, 32'd1);
        chk("R7 no wake when disabled", {31'b0, wkup}, 32'd0);
        acc(1'b0, 1'b0, 8'h18, 32'h0, 3'b000);
        chk("R4 status after match", rd_s, 32'h1);
        acc(1'b1, 1'b0, 8'h1C, 32'h0, 3'b000);
        acc(1'b0, 1'b0, 8'h4C, 32'h0, 3'b010);
        acc(1'b0, 1'b0, 8'h18, 32'h0, 3'b000);
        chk("R4 masked overflow not recorded", rd_s, 32'h1);

        acc(1'b1, 1'b0, 8'h20, 32'h2, 3'b000);
        acc(1'b0, 1'b0, 8'h4C, 32'h0, 3'b010);
        chk("R7 wake pulse", {31'b0, wkup}, 32'd1);
        acc(1'b0, 1'b0, 8'h4C, 32'h0, 3'b000);
        chk("R7 wake one cycle", {31'b0, wkup}, 32'd0);

        acc(1'b1, 1'b0, 8'h18, 32'h6, 3'b000);
        chk("R6 zero bits keep status", {31'b0, irq}, 32'd1);
        acc(1'b1, 1'b0, 8'h18, 32'h1, 3'b000);
        chk("R6 clear by one", {31'b0, irq}, 32'd0);
        acc(1'b0, 1'b0, 8'h18, 32'h0, 3'b000);
        chk("R5 status empty", rd_s, 32'h0);

        acc(1'b1, 1'b0, 8'h1C, 32'h7, 3'b000);
        acc(1'b1, 1'b0, 8'h18, 32'h1, 3'b001);
        acc(1'b0, 1'b0, 8'h18, 32'h0, 3'b000);
        chk("R4 set beats clear", rd_s, 32'h1);

        acc(1'b1, 1'b0, 8'h18, 32'h4, 3'b000);
        chk("R13 capture rearm", {31'b0, rm_s}, 32'd1);
        acc(1'b1, 1'b0, 8'h28, 32'h77, 3'b000);
        chk("R13 counter load", {31'b0, ld_s}, 32'd1);
        chk("R13 counter data", cd_s, 32'h77);
        acc(1'b1, 1'b0, 8'h30, 32'h0, 3'b000);
        chk("R13 trigger", {31'b0, tg_s}, 32'd1);
        chk("R13 no load on trigger", {31'b0, ld_s}, 32'd0);

        acc(1'b1, 1'b0, 8'h40, 32'h6, 3'b000);
        chk("R9 soft reset via interface", {31'b0, sr_s}, 32'd1);
        chk("R9 irq cleared", {31'b0, irq}, 32'd0);
        acc(1'b0, 1'b0, 8'h40, 32'h0, 3'b000);
        chk("R9 posted restored", rd_s, 32'h4);
        acc(1'b0, 1'b0, 8'h1C, 32'h0, 3'b000);
        chk("R9 enable cleared", rd_s, 32'h0);
        acc(1'b0, 1'b0, 8'h38, 32'h0, 3'b000);
        chk("R9 match cleared", rd_s, 32'h0);
        acc(1'b0, 1'b0, 8'h24, 32'h0, 3'b000);
        chk("R9 control cleared", rd_s, 32'h0);

        acc(1'b1, 1'b0, 8'h40, 32'h0, 3'b000);
        acc(1'b0, 1'b0, 8'h40, 32'h0, 3'b000);
        chk("R2 posted writable", rd_s, 32'h0);

        acc(1'b1, 1'b0, 8'h2C, 32'h99, 3'b000);
        acc(1'b1, 1'b1, 8'h10, 32'h0000_0002, 3'b000);
        chk("R10 low half no commit", {31'b0, sr_s}, 32'd0);
        acc(1'b1, 1'b1, 8'h12, 32'h0, 3'b000);
        chk("R9 soft reset via config half", {31'b0, sr_s}, 32'd1);
        acc(1'b0, 1'b0, 8'h2C, 32'h0, 3'b000);
        chk("R9 reload cleared", rd_s, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule